// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible register layer of a 16550-compatible serial port. A processor reaches it over a simple single-cycle read/write bus with byte addresses and 4-byte register spacing. It holds the line format, the baud divisor, the interrupt enables, the FIFO mode, a scratch byte and the sticky receive error flags. It turns the data register into push and pop strobes toward external transmit and receive queues, and it exports the decoded line format to the serialiser.

A latch-access bit in the line-control register swaps the two lowest addresses over to the 16-bit divisor. The FIFO-control address is write-only, and reading it returns the interrupt identification code. The identification code is formed from a fixed priority: receive line errors come before received data. It is re-registered every cycle and drives a single interrupt line. Error flags are sticky and clear when the line-status register is read.

Top module: `uart_regfile`

## Requirements
- R1: After reset, line control, interrupt enable, divisor, scratch and modem control read 0, the identification code is 0b0001, the FIFO is off and `irq` is low. An address that is not one of the eight register offsets reads 0, and writes to it have no effect.
- R2: Scratch (0x1C) is an 8-bit location that reads back the last value written to it.
- R3: Line control (0x0C) reads back all 8 bits. `word_len` equals bits 1:0 (0 = 5 bits, 3 = 8 bits). `stop_cfg` is 0 for one stop bit when bit 2 is clear. When bit 2 is set, `stop_cfg` is 1 (one and a half) for 5-bit words and 2 (two) otherwise. `par_mode` is 0 (none) when bit 3 is clear. With bit 6 clear it is 1 (odd) or 2 (even) by bit 4. With bit 6 set it is 3 (forced 1) when bit 4 is clear and 4 (forced 0) when bit 4 is set.
- R4: While line-control bit 7 is set, 0x00 reads and writes divisor bits 7:0 and 0x04 divisor bits 15:8, and data or enable side effects do not occur. While it is clear, 0x04 is the interrupt enable register: bits 3:0 are stored and bits 7:4 read 0.
- R5: With bit 7 clear, a write to 0x00 raises `tx_push` in the same cycle, or `loop_push` instead when loopback (modem control bit 4) is set. `tx_byte` carries the written byte. The two strobes are never high together.
- R6: With bit 7 clear, a read of 0x00 returns `rx_head` and raises `rx_pop` in the same cycle. With bit 7 set, no pop occurs.
- R7: Line status (0x14) reads {0, 1, 1, break, framing, parity, overrun, data-ready}. Data-ready is `rx_level != 0`. Each error bit is set by a one-cycle pulse on its input and stays set.
- R8: Reading line status clears the four error bits for the following cycles and leaves data-ready alone. An error pulse in the same cycle as that read stays set.
- R9: Writing 0x08 sets the FIFO enable from bit 0, pulses `rx_flush` in that cycle when bit 1 is set, and sets the receive trigger from bits 7:6. Reading 0x08 returns {enable, enable, 0, 0, id[3:0]}.
- R10: The identification code is 0b0110 when enable bit 2 is set and any error bit is set. Otherwise it is 0b0100 when enable bit 0 is set, `rx_level` is nonzero, and either the FIFO is off or the level exceeds the trigger threshold. The thresholds are 0, DEPTH/4, DEPTH/2 and DEPTH-2 for trigger values 0 to 3. In all other cases the code is 0b0001. The code reflects the state one cycle earlier.
- R11: `irq` is high exactly when the identification code is not 0b0001.
- R12: Modem control (0x10) reads back bit 4 only. Modem status (0x18) always reads 0x04, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (enables read side effects) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| rx_level | input | LVL_W | Receive queue fill level |
| rx_head | input | 8 | Byte at the receive queue head |
| rx_err_overrun | input | 1 | Overrun event pulse |
| rx_err_parity | input | 1 | Parity error event pulse |
| rx_err_framing | input | 1 | Framing error event pulse |
| rx_err_break | input | 1 | Break event pulse |
| rx_pop | output | 1 | Pop the receive queue |
| rx_flush | output | 1 | Clear the receive queue |
| tx_push | output | 1 | Push `tx_byte` to the transmitter |
| loop_push | output | 1 | Push `tx_byte` into the receive path (loopback) |
| tx_byte | output | 8 | Byte being written |
| word_len | output | 2 | Data bits minus 5 |
| stop_cfg | output | 2 | 0 one, 1 one and a half, 2 two stop bits |
| par_mode | output | 3 | 0 none, 1 odd, 2 even, 3 forced 1, 4 forced 0 |
| divisor | output | 16 | Baud divisor |
| fifo_on | output | 1 | FIFO mode enabled |
| loop_on | output | 1 | Loopback enabled |
| irq | output | 1 | Interrupt request |

## Verification
The strobes `tx_push`, `loop_push`, `rx_pop` and `rx_flush`, and the read data, are combinational. The bench therefore samples them one time unit after driving the bus, before the next rising edge. Register contents and the exported line settings change at the edge that takes the write, so they are sampled at the following falling edge. The identification code and `irq` come one register later. After any change to enables, FIFO mode, level or error inputs, the bench lets two rising edges pass before it compares them. It sweeps all enable, FIFO-mode, trigger and level combinations, with and without a pending error.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    localparam logic [7:0] OFF_DATA = 8'h00;
    localparam logic [7:0] OFF_IER  = 8'h04;
    localparam logic [7:0] OFF_IIR  = 8'h08;
    localparam logic [7:0] OFF_LCR  = 8'h0C;
    localparam logic [7:0] OFF_MCR  = 8'h10;
    localparam logic [7:0] OFF_LSR  = 8'h14;
    localparam logic [7:0] OFF_MSR  = 8'h18;
    localparam logic [7:0] OFF_SCR  = 8'h1C;

    localparam logic [7:0] MSR_VALUE = 8'h04;

    localparam logic [3:0] ID_NONE = 4'b0001;
    localparam logic [3:0] ID_DATA = 4'b0100;
    localparam logic [3:0] ID_LINE = 4'b0110;

    typedef enum logic [2:0] {
        PAR_NONE  = 3'd0,
        PAR_ODD   = 3'd1,
        PAR_EVEN  = 3'd2,
        PAR_MARK  = 3'd3,
        PAR_SPACE = 3'd4
    } par_e;

    typedef enum logic [1:0] {
        STOP_ONE      = 2'd0,
        STOP_ONE_HALF = 2'd1,
        STOP_TWO      = 2'd2
    } stop_e;

    // err: [0] overrun, [1] parity, [2] framing, [3] break
    typedef struct packed {
        logic [15:0] divisor;
        logic [3:0]  ier;
        logic [7:0]  lcr;
        logic        loopback;
        logic [3:0]  err;
        logic [7:0]  scratch;
        logic        fifo_en;
        logic [1:0]  trig;
        logic [3:0]  iid;
    } regs_t;

endpackage

// File: rtl/uart_line_cfg.sv
module uart_line_cfg
    import uart_rf_pkg::*;
(
    input  logic [4:0] fmt,
    input  logic       stick,
    output logic [1:0] word_len,
    output stop_e      stop_cfg,
    output par_e       par_mode
);

    always_comb begin
        word_len = fmt[1:0];

        if (!fmt[2])
            stop_cfg = STOP_ONE;
        else if (fmt[1:0] == 2'd0)
            stop_cfg = STOP_ONE_HALF;
        else
            stop_cfg = STOP_TWO;

        if (!fmt[3])
            par_mode = PAR_NONE;
        else if (!stick)
            par_mode = fmt[4] ? PAR_EVEN : PAR_ODD;
        else
            par_mode = fmt[4] ? PAR_SPACE : PAR_MARK;
    end

endmodule

// File: rtl/uart_rx_trig.sv
module uart_rx_trig #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic [1:0]       trig,
    input  logic [LVL_W-1:0] level,
    output logic             met
);

    localparam int THR_QTR  = DEPTH / 4;
    localparam int THR_HALF = DEPTH / 2;
    localparam int THR_NEAR = DEPTH - 2;

    logic [LVL_W-1:0] thr;

    always_comb begin
        unique case (trig)
            2'd0: thr = '0;
            2'd1: thr = LVL_W'(THR_QTR);
            2'd2: thr = LVL_W'(THR_HALF);
            default: thr = LVL_W'(THR_NEAR);
        endcase
        met = !fifo_en || (level > thr);
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_rf_pkg::*;
(
    input  logic       line_en,
    input  logic       data_en,
    input  logic       err_any,
    input  logic       ready,
    input  logic       trig_met,
    output logic [3:0] code
);

    always_comb begin
        if (line_en && err_any)
            code = ID_LINE;
        else if (data_en && ready && trig_met)
            code = ID_DATA;
        else
            code = ID_NONE;
    end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [7:0]        rx_head,
    input  logic              rx_err_overrun,
    input  logic              rx_err_parity,
    input  logic              rx_err_framing,
    input  logic              rx_err_break,
    output logic              rx_pop,
    output logic              rx_flush,
    output logic              tx_push,
    output logic              loop_push,
    output logic [7:0]        tx_byte,
    output logic [1:0]        word_len,
    output logic [1:0]        stop_cfg,
    output logic [2:0]        par_mode,
    output logic [15:0]       divisor,
    output logic              fifo_on,
    output logic              loop_on,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(OFF_IER);
    localparam logic [ADDR_W-1:0] A_IIR  = ADDR_W'(OFF_IIR);
    localparam logic [ADDR_W-1:0] A_LCR  = ADDR_W'(OFF_LCR);
    localparam logic [ADDR_W-1:0] A_MCR  = ADDR_W'(OFF_MCR);
    localparam logic [ADDR_W-1:0] A_LSR  = ADDR_W'(OFF_LSR);
    localparam logic [ADDR_W-1:0] A_MSR  = ADDR_W'(OFF_MSR);
    localparam logic [ADDR_W-1:0] A_SCR  = ADDR_W'(OFF_SCR);

    regs_t st_d, st_q;

    logic       dlab;
    logic       ready;
    logic       trig_met;
    logic [3:0] code_now;
    logic [3:0] new_err;
    stop_e      stop_w;
    par_e       par_w;

    assign dlab    = st_q.lcr[7];
    assign ready   = (rx_level != '0);
    assign new_err = {rx_err_break, rx_err_framing, rx_err_parity, rx_err_overrun};

    uart_line_cfg u_line (
        .fmt      (st_q.lcr[4:0]),
        .stick    (st_q.lcr[6]),
        .word_len (word_len),
        .stop_cfg (stop_w),
        .par_mode (par_w)
    );

    uart_rx_trig #(
        .DEPTH (FIFO_DEPTH),
        .LVL_W (LVL_W)
    ) u_trig (
        .fifo_en (st_q.fifo_en),
        .trig    (st_q.trig),
        .level   (rx_level),
        .met     (trig_met)
    );

    uart_irq_prio u_prio (
        .line_en  (st_q.ier[2]),
        .data_en  (st_q.ier[0]),
        .err_any  (|st_q.err),
        .ready    (ready),
        .trig_met (trig_met),
        .code     (code_now)
    );

    // next-state and strobes
    always_comb begin
        st_d      = st_q;
        rx_pop    = 1'b0;
        rx_flush  = 1'b0;
        tx_push   = 1'b0;
        loop_push = 1'b0;

        if (bus_wr) begin
            unique case (bus_addr)
                A_DATA: begin
                    if (dlab)
                        st_d.divisor[7:0] = bus_wdata;
                    else if (st_q.loopback)
                        loop_push = 1'b1;
                    else
                        tx_push = 1'b1;
                end
                A_IER: begin
                    if (dlab)
                        st_d.divisor[15:8] = bus_wdata;
                    else
                        st_d.ier = bus_wdata[3:0];
                end
                A_IIR: begin
                    st_d.fifo_en = bus_wdata[0];
                    rx_flush     = bus_wdata[1];
                    st_d.trig    = bus_wdata[7:6];
                end
                A_LCR:   st_d.lcr      = bus_wdata;
                A_MCR:   st_d.loopback = bus_wdata[4];
                A_SCR:   st_d.scratch  = bus_wdata;
                default: ;
            endcase
        end

        if (bus_rd && bus_addr == A_DATA && !dlab)
            rx_pop = 1'b1;

        if (bus_rd && bus_addr == A_LSR)
            st_d.err = new_err;
        else
            st_d.err = st_q.err | new_err;

        st_d.iid = code_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.iid <= ID_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = dlab ? st_q.divisor[7:0] : rx_head;
            A_IER:   bus_rdata = dlab ? st_q.divisor[15:8] : {4'b0, st_q.ier};
            A_IIR:   bus_rdata = {st_q.fifo_en, st_q.fifo_en, 2'b00, st_q.iid};
            A_LCR:   bus_rdata = st_q.lcr;
            A_MCR:   bus_rdata = {3'b000, st_q.loopback, 4'b0000};
            A_LSR:   bus_rdata = {3'b011, st_q.err, ready};
            A_MSR:   bus_rdata = MSR_VALUE;
            A_SCR:   bus_rdata = st_q.scratch;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign tx_byte  = bus_wdata;
    assign stop_cfg = stop_w;
    assign par_mode = par_w;
    assign divisor  = st_q.divisor;
    assign fifo_on  = st_q.fifo_en;
    assign loop_on  = st_q.loopback;
    assign irq      = (st_q.iid != ID_NONE);

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk
    import uart_rf_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_rdata,
    input logic              rx_err_overrun,
    input logic              rx_err_parity,
    input logic              rx_err_framing,
    input logic              rx_err_break,
    input logic              tx_push,
    input logic              loop_push,
    input logic              irq,
    input logic              dlab_q,
    input logic [3:0]        ier_q,
    input logic [3:0]        err_q
);

    logic any_new;
    assign any_new = rx_err_overrun | rx_err_parity | rx_err_framing | rx_err_break;

    // R5: at most one push strobe per write
    p_single_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_push && loop_push));

    // R4: divisor bank suppresses data side effects
    p_dlab_no_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dlab_q |-> (!tx_push && !loop_push));

    // R7: parity event is recorded on the next cycle
    p_parity_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err_parity |=> err_q[1]);

    // R8: a clean line-status read leaves no error behind
    p_lsr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(OFF_LSR) && !any_new) |=> (err_q == 4'b0000));

    // R10: pending error with line enable raises the request next cycle
    p_line_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_q[2] && (err_q != 4'b0000)) |=> irq);

    // R11: with both used enables clear the request falls
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ier_q[0] && !ier_q[2]) |=> !irq);

    // R12: modem status reads constant
    p_msr_const_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFF_MSR)) |-> (bus_rdata == MSR_VALUE));

endmodule

bind uart_regfile uart_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_rd         (bus_rd),
    .bus_addr       (bus_addr),
    .bus_rdata      (bus_rdata),
    .rx_err_overrun (rx_err_overrun),
    .rx_err_parity  (rx_err_parity),
    .rx_err_framing (rx_err_framing),
    .rx_err_break   (rx_err_break),
    .tx_push        (tx_push),
    .loop_push      (loop_push),
    .irq            (irq),
    .dlab_q         (st_q.lcr[7]),
    .ier_q          (st_q.ier),
    .err_q          (st_q.err)
);

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;

    localparam int DEPTH = 16;
    localparam int LW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [LW-1:0] rx_level = '0;
    logic [7:0]    rx_head = 8'h00;
    logic          e_ovr = 1'b0, e_par = 1'b0, e_frm = 1'b0, e_brk = 1'b0;
    logic          rx_pop, rx_flush, tx_push, loop_push;
    logic [7:0]    tx_byte;
    logic [1:0]    word_len, stop_cfg;
    logic [2:0]    par_mode;
    logic [15:0]   divisor;
    logic          fifo_on, loop_on, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    uart_regfile #(.ADDR_W(8), .FIFO_DEPTH(DEPTH), .LVL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_level(rx_level), .rx_head(rx_head),
        .rx_err_overrun(e_ovr), .rx_err_parity(e_par),
        .rx_err_framing(e_frm), .rx_err_break(e_brk),
        .rx_pop(rx_pop), .rx_flush(rx_flush), .tx_push(tx_push),
        .loop_push(loop_push), .tx_byte(tx_byte), .word_len(word_len),
        .stop_cfg(stop_cfg), .par_mode(par_mode), .divisor(divisor),
        .fifo_on(fifo_on), .loop_on(loop_on), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_stop(input logic [7:0] v);
        if (!v[2]) return 2'd0;
        return (v[1:0] == 2'd0) ? 2'd1 : 2'd2;
    endfunction

    function automatic logic [2:0] exp_par(input logic [7:0] v);
        if (!v[3]) return 3'd0;
        if (!v[6]) return v[4] ? 3'd2 : 3'd1;
        return v[4] ? 3'd4 : 3'd3;
    endfunction

    function automatic logic [3:0] exp_id(input logic [3:0] ier, input bit err,
                                           input bit fe, input int trig, input int lvl);
        int thr;
        thr = (trig == 0) ? 0 : (trig == 1) ? DEPTH/4 : (trig == 2) ? DEPTH/2 : DEPTH-2;
        if (ier[2] && err) return 4'b0110;
        if (ier[0] && lvl != 0 && (!fe || lvl > thr)) return 4'b0100;
        return 4'b0001;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h0C, v); check("R1 lcr", v, 8'h00);
        rd(8'h04, v); check("R1 ier", v, 8'h00);
        rd(8'h1C, v); check("R1 scratch", v, 8'h00);
        rd(8'h10, v); check("R1 mcr", v, 8'h00);
        rd(8'h08, v); check("R1 iir", v, 8'h01);
        check("R1 irq", irq, 0);
        check("R1 divisor", divisor, 0);
        check("R1 fifo", fifo_on, 0);
        wr(8'h1D, 8'hFF);
        rd(8'h1C, v); check("R1 misaligned write", v, 8'h00);
        rd(8'h1D, v); check("R1 unmapped read", v, 8'h00);

        // R12 modem status
        rd(8'h18, v); check("R12 msr reset", v, 8'h04);
        wr(8'h18, 8'hFF);
        rd(8'h18, v); check("R12 msr write ignored", v, 8'h04);

        // R2 scratch sweep
        for (int i = 0; i < 256; i++) begin
            wr(8'h1C, 8'(i));
            rd(8'h1C, v); check("R2 scratch", v, 32'(i));
        end

        // R3 line control sweep
        for (int i = 0; i < 256; i++) begin
            wr(8'h0C, 8'(i));
            check("R3 word_len", word_len, 32'(i & 3));
            check("R3 stop_cfg", stop_cfg, exp_stop(8'(i)));
            check("R3 par_mode", par_mode, exp_par(8'(i)));
            rd(8'h0C, v); check("R3 readback", v, 32'(i));
        end

        // R4 divisor banking
        wr(8'h0C, 8'h80);
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 8'h34; bus_wr = 1'b1;
        #1 check("R4 no tx_push while banked", {tx_push, loop_push}, 0);
        @(negedge clk); bus_wr = 1'b0;
        wr(8'h04, 8'h12);
        check("R4 divisor", divisor, 16'h1234);
        @(negedge clk);
        rx_head = 8'hA5; bus_addr = 8'h00; bus_rd = 1'b1;
        #1 check("R4 div low read", bus_rdata, 8'h34);
        check("R6 no pop while banked", rx_pop, 0);
        @(negedge clk); bus_rd = 1'b0;
        rd(8'h04, v); check("R4 div high read", v, 8'h12);
        wr(8'h0C, 8'h00);
        wr(8'h04, 8'hFF);
        rd(8'h04, v); check("R4 ier low nibble", v, 8'h0F);
        check("R4 divisor kept", divisor, 16'h1234);
        wr(8'h04, 8'h00);

        // R6 data read pops
        @(negedge clk);
        bus_addr = 8'h00; bus_rd = 1'b1;
        #1 check("R6 head data", bus_rdata, 8'hA5);
        check("R6 pop", rx_pop, 1);
        @(negedge clk); bus_rd = 1'b0;

        // R5 transmit and loopback
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 8'h3C; bus_wr = 1'b1;
        #1 check("R5 tx_push", {tx_push, loop_push}, 2'b10);
        check("R5 tx_byte", tx_byte, 8'h3C);
        @(negedge clk); bus_wr = 1'b0;
        wr(8'h10, 8'hFF);
        rd(8'h10, v); check("R12 mcr bit4 only", v, 8'h10);
        check("R5 loop_on", loop_on, 1);
        @(negedge clk);
        bus_addr = 8'h00; bus_wdata = 8'h5A; bus_wr = 1'b1;
        #1 check("R5 loop_push", {tx_push, loop_push}, 2'b01);
        check("R5 loop byte", tx_byte, 8'h5A);
        @(negedge clk); bus_wr = 1'b0;
        wr(8'h10, 8'h00);

        // R9 FIFO control
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 8'hC3; bus_wr = 1'b1;
        #1 check("R9 flush pulse", rx_flush, 1);
        @(negedge clk); bus_wr = 1'b0;
        check("R9 fifo_on", fifo_on, 1);
        rd(8'h08, v); check("R9 iir fifo bits", v, 8'hC1);
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 8'h00; bus_wr = 1'b1;
        #1 check("R9 no flush", rx_flush, 0);
        @(negedge clk); bus_wr = 1'b0;
        rd(8'h08, v); check("R9 iir fifo off", v, 8'h01);

        // R7 / R8 line status
        rx_level = 5'd3;
        @(negedge clk); e_par = 1'b1;
        @(negedge clk); e_par = 1'b0;
        rd(8'h14, v); check("R7 parity flag", v, 8'h65);
        rd(8'h14, v); check("R8 cleared by read", v, 8'h61);
        @(negedge clk); e_ovr = 1'b1; e_frm = 1'b1;
        @(negedge clk); e_ovr = 1'b0; e_frm = 1'b0;
        @(negedge clk);
        bus_addr = 8'h14; bus_rd = 1'b1; e_brk = 1'b1;
        #1 check("R7 overrun framing", bus_rdata, 8'h6B);
        @(negedge clk); bus_rd = 1'b0; e_brk = 1'b0;
        rd(8'h14, v); check("R8 same-cycle break kept", v, 8'h71);
        rd(8'h14, v); check("R8 break cleared", v, 8'h61);
        rx_level = 5'd0;
        rd(8'h14, v); check("R7 data ready low", v, 8'h60);

        // R10 / R11 interrupt sweep
        for (int ie = 0; ie < 4; ie++) begin
            for (int fe = 0; fe < 2; fe++) begin
                for (int tg = 0; tg < 4; tg++) begin
                    for (int lv = 0; lv <= DEPTH; lv++) begin
                        for (int er = 0; er < 2; er++) begin
                            logic [3:0] ier, id;
                            ier = {1'b0, ie[1], 1'b0, ie[0]};
                            wr(8'h04, {4'b0, ier});
                            wr(8'h08, {tg[1:0], 5'b0, fe[0]});
                            rx_level = LW'(lv);
                            if (er != 0) begin
                                @(negedge clk); e_frm = 1'b1;
                                @(negedge clk); e_frm = 1'b0;
                            end
                            settle();
                            id = exp_id(ier, er != 0, fe != 0, tg, lv);
                            bus_addr = 8'h08;
                            #1 check("R10 iid", bus_rdata, {fe[0], fe[0], 2'b00, id});
                            check("R11 irq", irq, (id != 4'b0001));
                            if (er != 0) rd(8'h14, v);
                        end
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule